// File: doc/BRIEF.md
# 27-Channel Priority Interrupt Acknowledger

This block picks exactly one interrupt to acknowledge out of three request buses of nine channels each. A shared nine-bit enable vector gates the requests. Clearing enable bit i removes channel i from all three buses at the same time. Among the requests that remain, any request on bus A wins over any on bus B, and any on bus B wins over any on bus C. Inside the winning bus, the channel with the highest index wins.

The result appears on three one-hot bus flags and a four-bit binary channel number. The block holds no request state: it decides again from its current inputs every cycle. The `REG_OUT` parameter selects the output timing. With `REG_OUT=0` the outputs follow the inputs combinationally. With `REG_OUT=1` they come from a bank of output flops with asynchronous reset, one cycle behind the inputs.

The 36 input bits (three request buses plus the enable bus) form one flat stimulus word. A wide pattern generator can drive it directly.

Top module: `prio_ack`

## Requirements
- R1: When enable bit i is 0, request bit i on buses A, B and C has no effect on any output, and the acknowledged channel always has its enable bit set.
- R2: Any enabled request on bus A wins over every enabled request on buses B and C. Any enabled request on bus B wins over every enabled request on bus C. The channel index plays no part in this choice.
- R3: Within the winning bus, the acknowledged channel is the highest-indexed channel that is both requesting and enabled.
- R4: No more than one of the bus flags `ack_a`, `ack_b`, `ack_c` is high at any time.
- R5: When no request is both set and enabled, all three flags are low and `ack_chan` is 0.
- R6: `ack_chan` carries the winning channel as an unsigned binary number from 0 to 8. Bit 0 of each request and enable bus is channel 0. Values 9 to 15 never appear.
- R7: With `REG_OUT=1`, reset drives all outputs to 0, and the outputs show the decision for the inputs present at the previous rising clock edge. With `REG_OUT=0`, the outputs reflect the current inputs without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rst_n | input | 1 | Asynchronous active-low reset of the output register |
| req_a | input | 9 | Requests on bus A, the highest-priority bus |
| req_b | input | 9 | Requests on bus B |
| req_c | input | 9 | Requests on bus C, the lowest-priority bus |
| chan_en | input | 9 | Per-channel enable, shared by all three buses |
| ack_a | output | 1 | Bus A holds the acknowledged request |
| ack_b | output | 1 | Bus B holds the acknowledged request |
| ack_c | output | 1 | Bus C holds the acknowledged request |
| ack_chan | output | 4 | Binary index of the acknowledged channel |

## Verification
The bench builds two copies of the block with the default nine channels per bus: one with `REG_OUT=0` and one with `REG_OUT=1`. Both copies see the same stimulus. The combinational copy exposes the priority decision directly. The registered copy adds checks on the one-cycle lag and on the reset value. The bench sweeps all 512 enable patterns, which reaches every masking combination the shared enable can produce. Directed cases place a low-index A request against high-index B and C requests, and test a single request on each of the 27 channels.

// File: rtl/prio_ack_pkg.sv
package prio_ack_pkg;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_A    = 2'd1,
    SRC_B    = 2'd2,
    SRC_C    = 2'd3
  } src_t;

  // Position of the most significant set bit; 0 when the vector is empty.
  function automatic logic [4:0] msb_pos(input logic [31:0] v);
    logic [4:0] p;
    p = '0;
    for (int i = 0; i < 32; i++) begin
      if (v[i]) p = 5'(i);
    end
    return p;
  endfunction

  // Fixed bus ranking: A before B before C.
  function automatic src_t rank_src(input logic hit_a, input logic hit_b,
                                    input logic hit_c);
    if (hit_a)      return SRC_A;
    else if (hit_b) return SRC_B;
    else if (hit_c) return SRC_C;
    else            return SRC_NONE;
  endfunction

  // Flag vector ordered {c, b, a}.
  function automatic logic [2:0] src_flags(input src_t s);
    case (s)
      SRC_A:   return 3'b001;
      SRC_B:   return 3'b010;
      SRC_C:   return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

endpackage

// File: rtl/prio_ack_scan.sv
module prio_ack_scan #(
  parameter int N  = 9,
  parameter int IW = 4
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  en,
  output logic [N-1:0]  live,
  output logic          hit,
  output logic [IW-1:0] idx
);
  import prio_ack_pkg::*;

  logic [4:0] pos;

  assign live = req & en;
  assign hit  = |live;
  assign pos  = msb_pos(32'(live));
  assign idx  = IW'(pos);

endmodule

// File: rtl/prio_ack_merge.sv
module prio_ack_merge #(
  parameter int IW = 4
) (
  input  logic [2:0]          hit,
  input  logic [2:0][IW-1:0]  idx,
  output logic [2:0]          flags,
  output logic [IW-1:0]       chan
);
  import prio_ack_pkg::*;

  src_t win;

  assign win   = rank_src(hit[0], hit[1], hit[2]);
  assign flags = src_flags(win);

  always_comb begin
    case (win)
      SRC_A:   chan = idx[0];
      SRC_B:   chan = idx[1];
      SRC_C:   chan = idx[2];
      default: chan = '0;
    endcase
  end

endmodule

// File: rtl/prio_ack.sv
module prio_ack #(
  parameter int CHANNELS = 9,
  parameter int CHAN_W   = 4,
  parameter bit REG_OUT  = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] req_a,
  input  logic [CHANNELS-1:0] req_b,
  input  logic [CHANNELS-1:0] req_c,
  input  logic [CHANNELS-1:0] chan_en,
  output logic                ack_a,
  output logic                ack_b,
  output logic                ack_c,
  output logic [CHAN_W-1:0]   ack_chan
);
  localparam int NBUS = 3;

  logic [NBUS-1:0][CHANNELS-1:0] bus_req;
  logic [NBUS-1:0][CHANNELS-1:0] bus_live;
  logic [NBUS-1:0]               bus_hit;
  logic [NBUS-1:0][CHAN_W-1:0]   bus_idx;

  // Decision before the optional output stage.
  logic [2:0]        nxt_flags;
  logic [CHAN_W-1:0] nxt_chan;
  logic              any_live;

  assign bus_req = {req_c, req_b, req_a};

  for (genvar g = 0; g < NBUS; g++) begin : g_scan
    prio_ack_scan #(.N(CHANNELS), .IW(CHAN_W)) u_scan (
      .req  (bus_req[g]),
      .en   (chan_en),
      .live (bus_live[g]),
      .hit  (bus_hit[g]),
      .idx  (bus_idx[g])
    );
  end

  assign any_live = |bus_hit;

  prio_ack_merge #(.IW(CHAN_W)) u_merge (
    .hit   (bus_hit),
    .idx   (bus_idx),
    .flags (nxt_flags),
    .chan  (nxt_chan)
  );

  if (REG_OUT) begin : g_reg
    logic [2:0]        q_flags;
    logic [CHAN_W-1:0] q_chan;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_flags <= '0;
        q_chan  <= '0;
      end else begin
        q_flags <= nxt_flags;
        q_chan  <= nxt_chan;
      end
    end
    assign {ack_c, ack_b, ack_a} = q_flags;
    assign ack_chan              = q_chan;
  end else begin : g_comb
    assign {ack_c, ack_b, ack_a} = nxt_flags;
    assign ack_chan              = nxt_chan;
  end

endmodule

// File: rtl/prio_ack_chk.sv
module prio_ack_chk #(
  parameter int CHANNELS = 9,
  parameter int CHAN_W   = 4,
  parameter bit REG_OUT  = 1'b0
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CHANNELS-1:0] req_a,
  input logic [CHANNELS-1:0] req_b,
  input logic [CHANNELS-1:0] req_c,
  input logic [CHANNELS-1:0] chan_en,
  input logic                any_live,
  input logic                ack_a,
  input logic                ack_b,
  input logic                ack_c,
  input logic [CHAN_W-1:0]   ack_chan
);
  // Inputs aligned with the outputs they produced.
  logic [CHANNELS-1:0] oa, ob, oc, oe;
  logic                o_vld;

  if (REG_OUT) begin : g_lag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        o_vld <= 1'b0;
        oa <= '0; ob <= '0; oc <= '0; oe <= '0;
      end else begin
        o_vld <= 1'b1;
        oa <= req_a; ob <= req_b; oc <= req_c; oe <= chan_en;
      end
    end
  end else begin : g_now
    assign o_vld = 1'b1;
    assign oa = req_a;
    assign ob = req_b;
    assign oc = req_c;
    assign oe = chan_en;
  end

  logic                any_flag;
  logic [CHANNELS-1:0] win_live, en_sh, live_sh;

  assign any_flag = ack_a | ack_b | ack_c;
  assign win_live = (ack_a ? oa : ack_b ? ob : oc) & oe;
  assign en_sh    = oe >> ack_chan;
  assign live_sh  = win_live >> ack_chan;

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ack_a, ack_b, ack_c})); // R4

  AST_CHAN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ack_chan < CHAN_W'(CHANNELS)); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && ((oa | ob | oc) & oe) == '0) |-> (!any_flag && ack_chan == '0)); // R5

  AST_A_OVER_REST: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && (oa & oe) != '0) |-> ack_a); // R2

  AST_B_OVER_C: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && (oa & oe) == '0 && (ob & oe) != '0) |-> ack_b); // R2

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && any_flag) |-> en_sh[0]); // R1

  AST_WINNER_HIGHEST: assert property (@(posedge clk) disable iff (!rst_n)
    (o_vld && any_flag) |-> (live_sh == CHANNELS'(1))); // R3

  AST_LIVE_MEANS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (REG_OUT == 1'b0 && any_live) |-> any_flag); // R5

endmodule

bind prio_ack prio_ack_chk #(
  .CHANNELS (CHANNELS),
  .CHAN_W   (CHAN_W),
  .REG_OUT  (REG_OUT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_a    (req_a),
  .req_b    (req_b),
  .req_c    (req_c),
  .chan_en  (chan_en),
  .any_live (any_live),
  .ack_a    (ack_a),
  .ack_b    (ack_b),
  .ack_c    (ack_c),
  .ack_chan (ack_chan)
);

// File: tb/prio_ack_test.sv
`timescale 1ns/1ps
module prio_ack_test;
  localparam int CH = 9;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] ra = '0, rb = '0, rc = '0, re = '0;

  logic       r_a, r_b, r_c;
  logic [3:0] r_ch;
  logic       c_a, c_b, c_c;
  logic [3:0] c_ch;

  int checks = 0;
  int errors = 0;
  logic [6:0] prev_exp = '0;

  always #2.5 clk = ~clk;

  prio_ack #(.CHANNELS(CH), .CHAN_W(4), .REG_OUT(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .req_a(ra), .req_b(rb), .req_c(rc), .chan_en(re),
    .ack_a(r_a), .ack_b(r_b), .ack_c(r_c), .ack_chan(r_ch));

  prio_ack #(.CHANNELS(CH), .CHAN_W(4), .REG_OUT(1'b0)) uut_comb (
    .clk(clk), .rst_n(rst_n), .req_a(ra), .req_b(rb), .req_c(rc), .chan_en(re),
    .ack_a(c_a), .ack_b(c_b), .ack_c(c_c), .ack_chan(c_ch));

  // Highest set bit found by scanning downward.
  function automatic logic [3:0] top_bit(input logic [CH-1:0] m);
    for (int i = CH - 1; i >= 0; i--) begin
      if (m[i]) return 4'(i);
    end
    return 4'd0;
  endfunction

  // Expected result packed as {a, b, c, chan}.
  function automatic logic [6:0] model(input logic [CH-1:0] a, b, c, e);
    if ((a & e) != '0) return {3'b100, top_bit(a & e)};
    if ((b & e) != '0) return {3'b010, top_bit(b & e)};
    if ((c & e) != '0) return {3'b001, top_bit(c & e)};
    return 7'd0;
  endfunction

  task automatic check(input string req, input logic [6:0] got, input logic [6:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got flags=%b chan=%0d expected flags=%b chan=%0d",
               req, got[6:4], got[3:0], exp[6:4], exp[3:0]);
    end
  endtask

  // Drive a pattern, check the combinational copy and the registered copy's lag,
  // then check the registered copy one edge later.
  task automatic apply(input logic [CH-1:0] a, b, c, e, input string req);
    logic [6:0] exp;
    @(negedge clk);
    ra = a; rb = b; rc = c; re = e;
    exp = model(a, b, c, e);
    #1;
    check(req, {c_a, c_b, c_c, c_ch}, exp);
    check("R7 lag", {r_a, r_b, r_c, r_ch}, prev_exp);
    @(negedge clk);
    check({req, " R7 reg"}, {r_a, r_b, r_c, r_ch}, exp);
    prev_exp = exp;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic [6:0] seen;
    void'($urandom(32'd20240611));
    ra = 9'h1ff; rb = 9'h1ff; rc = 9'h1ff; re = 9'h1ff;
    repeat (3) @(negedge clk);
    check("R7 reset", {r_a, r_b, r_c, r_ch}, 7'd0);
    rst_n = 1'b1;
    @(negedge clk);
    prev_exp = model(ra, rb, rc, re);

    apply(9'h1ff, 9'h1ff, 9'h1ff, 9'h1ff, "R3 all requests");
    apply(9'h001, 9'h100, 9'h100, 9'h1ff, "R2 low A beats high B/C");
    apply(9'h000, 9'h001, 9'h100, 9'h1ff, "R2 low B beats high C");
    apply(9'h1ff, 9'h1ff, 9'h1ff, 9'h000, "R5 fully masked");
    apply(9'h000, 9'h000, 9'h000, 9'h1ff, "R5 no requests");
    apply(9'h020, 9'h004, 9'h000, 9'h1df, "R1 masked A falls to B");
    apply(9'h1ff, 9'h000, 9'h000, 9'h0ff, "R1 top channel masked");

    for (int bus = 0; bus < 3; bus++) begin
      for (int ch = 0; ch < CH; ch++) begin
        logic [CH-1:0] one;
        one = CH'(1) << ch;
        apply(bus == 0 ? one : '0, bus == 1 ? one : '0, bus == 2 ? one : '0,
              9'h1ff, "R6 single request");
      end
    end

    for (int e = 0; e < 512; e++) begin
      apply(9'($urandom), 9'($urandom), 9'($urandom), 9'(e), "R1 enable sweep");
    end

    for (int n = 0; n < 1500; n++) begin
      logic [CH-1:0] a, b, c;
      a = 9'($urandom) & 9'($urandom) & 9'($urandom);
      b = 9'($urandom) & 9'($urandom);
      c = 9'($urandom);
      apply(a, b, c, 9'($urandom), "R3 random");
      seen = {c_a, c_b, c_c, c_ch};
      check("R4 onehot flags", {$onehot0(seen[6:4]), 6'd0}, {1'b1, 6'd0});
      check("R6 channel range", {seen[3:0] < 4'd9, 6'd0}, {1'b1, 6'd0});
    end

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R7 reset midrun", {r_a, r_b, r_c, r_ch}, 7'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule